// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt requests from a small set of external request pins and from on-chip peripheral sources, plus one nonmaskable input. It qualifies every maskable source with a per-source enable bit and with the CPU's global mask bit. It chooses one winner by a fixed ranking and presents a single registered request line to the CPU, together with that winner's vector number.

External pins are active low. Each pin has a sense-mode bit. In level mode a pin requests service for as long as its synchronized value is low. In edge mode a falling edge sets a sticky flag. The flag holds until the CPU acknowledges that pin's vector or software clears it, so a pin pulse lasting a single clock is still caught. The nonmaskable input is rising-edge detected into a pending flag. That flag ignores the enables and the mask, but it is held clear while reset or standby is asserted.

The CPU takes an interrupt by pulsing `ack` while the request is high. The request and vector stay frozen until that pulse. The request drops on the acknowledge edge, and the arbiter picks a new winner on the following edge.

Top module: `prio_intc`

## Requirements
- R1: After reset `irq_out` is 0, `vec_out` is 0 and every edge flag and the nonmaskable pending flag are clear.
- R2: A maskable source whose enable bit (`ext_en[i]` or `per_en[j]`) is 0 never causes `irq_out` to rise.
- R3: While `cpu_mask` is 1 no external pin or peripheral source is accepted; the nonmaskable source is still accepted.
- R4: The ranking is fixed: the nonmaskable source first, then external pins in ascending index, then peripherals in ascending index.
- R5: Vector numbers are `VEC_NMI` (default 2) for the nonmaskable source, `EXT_BASE + i` (default 16 + i) for external pin i, and `PER_BASE + j` (default 32 + j) for peripheral j.
- R6: With `ext_edge_sel[i]` = 0 a pin requests only while its synchronized level is low; releasing the pin removes the request with no memory of it.
- R7: With `ext_edge_sel[i]` = 1 a falling edge, even one lasting a single cycle, sets a flag that keeps requesting after the pin returns high. The flag is set even while the pin is disabled, and it requests once the pin is enabled.
- R8: An edge flag clears on acknowledge of its own vector, or when `flag_clr_we` is 1 with `flag_clr_sel[i]` = 1. If a new edge arrives in the same cycle as a clear, the flag ends up set.
- R9: `irq_out` and `vec_out` hold their values until `ack` is seen with `irq_out` high. On that edge `irq_out` drops. On the next edge a new winner, if any, is loaded.
- R10: A rising edge on `nmi_in` sets a pending flag that requests with vector `VEC_NMI` regardless of enables and `cpu_mask`, and acknowledge of that vector clears it.
- R11: While `standby` is 1 the nonmaskable pending flag is held clear, and an edge that occurs during standby is not remembered afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Hardware standby; blocks the nonmaskable source |
| nmi_in | input | 1 | Nonmaskable request, rising-edge sensed |
| ext_pin_n | input | N_EXT | External request pins, active low |
| ext_edge_sel | input | N_EXT | Per-pin sense: 1 falling edge, 0 level |
| ext_en | input | N_EXT | Per-pin enable |
| flag_clr_we | input | 1 | Software clear strobe for edge flags |
| flag_clr_sel | input | N_EXT | Flags cleared by the strobe (1 = clear) |
| per_irq | input | N_PER | Peripheral request levels |
| per_en | input | N_PER | Per-peripheral enable |
| cpu_mask | input | 1 | Global mask for all maskable sources |
| ack | input | 1 | CPU acknowledge pulse |
| irq_out | output | 1 | Registered request to the CPU |
| vec_out | output | VEC_W | Registered vector of the presented source |

## Verification
Each result has its own due time in clock edges, counted from a change driven at a falling edge. A peripheral request shows on `irq_out` one edge later. A level pin passes through two synchronizer flops and the output register, so it shows after three edges. An edge pin or the nonmaskable input also needs the edge-flag stage, so it shows after four. After an `ack` edge the request is low one edge later, and the next winner appears on the edge after that. The bench drives only on falling edges and waits exactly those edge counts before sampling. It also checks that nothing has appeared one edge earlier, or that a held value has not moved, wherever the timing matters.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_PER  = 2'd3
    } src_kind_e;

endpackage

// File: rtl/intc_pin_capture.sv
module intc_pin_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic flag;
    } cap_t;

    cap_t q, d;
    logic fall;

    assign fall = q.prev & ~q.s2;

    always_comb begin
        d      = q;
        d.s1   = pin_n;
        d.s2   = q.s1;
        d.prev = q.s2;
        if (!edge_mode) begin
            d.flag = 1'b0;
        end else if (fall) begin
            d.flag = 1'b1;
        end else if (clr) begin
            d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1, flag: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign req = edge_mode ? q.flag : ~q.s2;

    // R8
    edge_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall) |=> (req || !edge_mode));

    // R6
    level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && q.s1 && q.s2) |=> (!req || edge_mode));

endmodule

// File: rtl/intc_nmi_capture.sv
module intc_nmi_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic nmi_in,
    input  logic clr,
    output logic pend
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic pend;
    } nmi_t;

    nmi_t q, d;
    logic rise;

    assign rise = q.s2 & ~q.prev;

    always_comb begin
        d      = q;
        d.s1   = nmi_in;
        d.s2   = q.s1;
        d.prev = q.s2;
        if (standby) begin
            d.pend = 1'b0;
        end else if (rise) begin
            d.pend = 1'b1;
        end else if (clr) begin
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pend = q.pend;

    // R11
    standby_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !pend);

    // R10
    nmi_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise) |=> !pend);

endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick
    import prio_intc_pkg::*;
#(
    parameter int N_EXT    = 4,
    parameter int N_PER    = 4,
    parameter int VEC_W    = 8,
    parameter int IDX_W    = 2,
    parameter int VEC_NMI  = 2,
    parameter int EXT_BASE = 16,
    parameter int PER_BASE = 32
) (
    input  logic             nmi_req,
    input  logic [N_EXT-1:0] ext_req,
    input  logic [N_PER-1:0] per_req,
    output logic             valid,
    output logic [VEC_W-1:0] vec,
    output src_kind_e        kind,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        valid = 1'b0;
        vec   = '0;
        kind  = SRC_NONE;
        idx   = '0;
        for (int j = N_PER - 1; j >= 0; j--) begin
            if (per_req[j]) begin
                valid = 1'b1;
                vec   = VEC_W'(PER_BASE + j);
                kind  = SRC_PER;
                idx   = IDX_W'(j);
            end
        end
        for (int i = N_EXT - 1; i >= 0; i--) begin
            if (ext_req[i]) begin
                valid = 1'b1;
                vec   = VEC_W'(EXT_BASE + i);
                kind  = SRC_EXT;
                idx   = IDX_W'(i);
            end
        end
        if (nmi_req) begin
            valid = 1'b1;
            vec   = VEC_W'(VEC_NMI);
            kind  = SRC_NMI;
            idx   = '0;
        end
    end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N_EXT    = 4,
    parameter int N_PER    = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_NMI  = 2,
    parameter int EXT_BASE = 16,
    parameter int PER_BASE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             nmi_in,
    input  logic [N_EXT-1:0] ext_pin_n,
    input  logic [N_EXT-1:0] ext_edge_sel,
    input  logic [N_EXT-1:0] ext_en,
    input  logic             flag_clr_we,
    input  logic [N_EXT-1:0] flag_clr_sel,
    input  logic [N_PER-1:0] per_irq,
    input  logic [N_PER-1:0] per_en,
    input  logic             cpu_mask,
    input  logic             ack,
    output logic             irq_out,
    output logic [VEC_W-1:0] vec_out
);

    localparam int MAXN  = (N_EXT > N_PER) ? N_EXT : N_PER;
    localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1;

    typedef struct packed {
        logic             irq;
        logic [VEC_W-1:0] vec;
        src_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } out_t;

    out_t q, d;

    logic             nmi_pend;
    logic             nmi_clr;
    logic             ack_take;
    logic [N_EXT-1:0] ext_raw;
    logic [N_EXT-1:0] ext_clr;
    logic [N_EXT-1:0] ext_live;
    logic [N_PER-1:0] per_live;
    logic             pick_valid;
    logic [VEC_W-1:0] pick_vec;
    src_kind_e        pick_kind;
    logic [IDX_W-1:0] pick_idx;

    assign ack_take = q.irq & ack;
    assign nmi_clr  = ack_take && (q.kind == SRC_NMI);
    assign ext_live = ext_raw & ext_en & {N_EXT{~cpu_mask}};
    assign per_live = per_irq & per_en & {N_PER{~cpu_mask}};

    genvar gi;
    generate
        for (gi = 0; gi < N_EXT; gi++) begin : g_pin
            assign ext_clr[gi] = (ack_take && (q.kind == SRC_EXT) && (q.idx == IDX_W'(gi)))
                               || (flag_clr_we && flag_clr_sel[gi]);
            intc_pin_capture u_cap (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_n     (ext_pin_n[gi]),
                .edge_mode (ext_edge_sel[gi]),
                .clr       (ext_clr[gi]),
                .req       (ext_raw[gi])
            );
        end
    endgenerate

    intc_nmi_capture u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .nmi_in  (nmi_in),
        .clr     (nmi_clr),
        .pend    (nmi_pend)
    );

    intc_prio_pick #(
        .N_EXT    (N_EXT),
        .N_PER    (N_PER),
        .VEC_W    (VEC_W),
        .IDX_W    (IDX_W),
        .VEC_NMI  (VEC_NMI),
        .EXT_BASE (EXT_BASE),
        .PER_BASE (PER_BASE)
    ) u_pick (
        .nmi_req (nmi_pend),
        .ext_req (ext_live),
        .per_req (per_live),
        .valid   (pick_valid),
        .vec     (pick_vec),
        .kind    (pick_kind),
        .idx     (pick_idx)
    );

    always_comb begin
        d = q;
        if (ack_take) begin
            d.irq = 1'b0;
        end else if (!q.irq && pick_valid) begin
            d.irq  = 1'b1;
            d.vec  = pick_vec;
            d.kind = pick_kind;
            d.idx  = pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{irq: 1'b0, vec: '0, kind: SRC_NONE, idx: '0};
        end else begin
            q <= d;
        end
    end

    assign irq_out = q.irq;
    assign vec_out = q.vec;

    // R9
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack) |=> (irq_out && $stable(vec_out)));

    // R9
    drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && ack) |=> !irq_out);

    // R3
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && cpu_mask && !nmi_pend) |=> !irq_out);

    // R2
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && !nmi_pend && ((ext_raw & ext_en) == '0) && ((per_irq & per_en) == '0))
        |=> !irq_out);

    // R4
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && nmi_pend) |=> (irq_out && vec_out == VEC_W'(VEC_NMI)));

endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;

    localparam int NE = 4;
    localparam int NP = 4;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          standby = 1'b0;
    logic          nmi_in = 1'b0;
    logic [NE-1:0] ext_pin_n = '1;
    logic [NE-1:0] ext_edge_sel = 4'b0101;
    logic [NE-1:0] ext_en = '0;
    logic          flag_clr_we = 1'b0;
    logic [NE-1:0] flag_clr_sel = '0;
    logic [NP-1:0] per_irq = '0;
    logic [NP-1:0] per_en = '0;
    logic          cpu_mask = 1'b0;
    logic          ack = 1'b0;
    logic          irq_out;
    logic [VW-1:0] vec_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    prio_intc u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby      (standby),
        .nmi_in       (nmi_in),
        .ext_pin_n    (ext_pin_n),
        .ext_edge_sel (ext_edge_sel),
        .ext_en       (ext_en),
        .flag_clr_we  (flag_clr_we),
        .flag_clr_sel (flag_clr_sel),
        .per_irq      (per_irq),
        .per_en       (per_en),
        .cpu_mask     (cpu_mask),
        .ack          (ack),
        .irq_out      (irq_out),
        .vec_out      (vec_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", irq_out, 0);
        chk("R1 vec after reset", vec_out, 0);
        ext_en = '1;
        tick(1);
        chk("R1 no stale flag", irq_out, 0);
        ext_en = '0;
    endtask

    task automatic t_enable_gate();
        per_irq = '1;
        per_en  = '0;
        tick(3);
        chk("R2 disabled peripherals", irq_out, 0);
        per_en = 4'b0100;
        tick(1);
        chk("R2 enabled peripheral irq", irq_out, 1);
        chk("R5 peripheral 2 vector", vec_out, 34);
        per_irq = '0;
        do_ack();
        per_en = '0;
        tick(1);
        chk("R9 idle after ack", irq_out, 0);
    endtask

    task automatic t_prio_peripherals();
        per_en  = '1;
        per_irq = 4'b0110;
        tick(1);
        chk("R4 lower peripheral wins", vec_out, 33);
        tick(2);
        chk("R9 held before ack", vec_out, 33);
        ack = 1'b1;
        per_irq[1] = 1'b0;
        tick(1);
        ack = 1'b0;
        chk("R9 low after ack", irq_out, 0);
        tick(1);
        chk("R9 reload next winner", irq_out, 1);
        chk("R9 next winner vector", vec_out, 34);
        per_irq = '0;
        do_ack();
        per_en = '0;
        tick(1);
    endtask

    task automatic t_mask_and_level();
        cpu_mask = 1'b1;
        ext_en = 4'b0010;
        per_en = 4'b0001;
        per_irq = 4'b0001;
        ext_pin_n[1] = 1'b0;
        tick(3);
        chk("R3 mask blocks maskable", irq_out, 0);
        cpu_mask = 1'b0;
        tick(1);
        chk("R4 external beats peripheral", irq_out, 1);
        chk("R5 external 1 vector", vec_out, 17);
        ext_pin_n[1] = 1'b1;
        tick(2);
        chk("R9 stable after pin release", vec_out, 17);
        do_ack();
        chk("R9 drop on ack", irq_out, 0);
        tick(1);
        chk("R6 level not latched", vec_out, 32);
        per_irq = '0;
        do_ack();
        per_en = '0;
        ext_en = '0;
        tick(1);
    endtask

    task automatic t_level_release();
        ext_en = 4'b1000;
        ext_pin_n[3] = 1'b0;
        tick(2);
        chk("R6 not yet after two edges", irq_out, 0);
        tick(1);
        chk("R6 level request", irq_out, 1);
        chk("R5 external 3 vector", vec_out, 19);
        ext_pin_n[3] = 1'b1;
        tick(2);
        do_ack();
        tick(1);
        chk("R6 released pin gone", irq_out, 0);
        ext_en = '0;
    endtask

    task automatic t_edge_pulse();
        ext_en = 4'b0100;
        ext_pin_n[2] = 1'b0;
        tick(1);
        ext_pin_n[2] = 1'b1;
        tick(2);
        chk("R7 not yet after three edges", irq_out, 0);
        tick(1);
        chk("R7 short pulse latched", irq_out, 1);
        chk("R5 external 2 vector", vec_out, 18);
        do_ack();
        tick(2);
        chk("R8 ack clears edge flag", irq_out, 0);
        ext_en = '0;
    endtask

    task automatic t_edge_disabled_and_clear();
        ext_pin_n[0] = 1'b0;
        tick(1);
        ext_pin_n[0] = 1'b1;
        tick(4);
        flag_clr_we = 1'b1;
        flag_clr_sel = 4'b0001;
        tick(1);
        flag_clr_we = 1'b0;
        flag_clr_sel = '0;
        ext_en = 4'b0001;
        tick(1);
        chk("R8 software clear", irq_out, 0);
        ext_en = '0;
        ext_pin_n[0] = 1'b0;
        tick(1);
        ext_pin_n[0] = 1'b1;
        tick(1);
        flag_clr_we = 1'b1;
        flag_clr_sel = 4'b0001;
        tick(1);
        flag_clr_we = 1'b0;
        flag_clr_sel = '0;
        chk("R2 disabled flag no irq", irq_out, 0);
        ext_en = 4'b0001;
        tick(1);
        chk("R8 set wins over clear", irq_out, 1);
        chk("R7 enabled later vector", vec_out, 16);
        do_ack();
        ext_en = '0;
        tick(1);
    endtask

    task automatic t_nmi();
        cpu_mask = 1'b1;
        nmi_in = 1'b1;
        tick(4);
        chk("R10 nmi under mask", irq_out, 1);
        chk("R5 nmi vector", vec_out, 2);
        do_ack();
        tick(1);
        chk("R10 ack clears nmi", irq_out, 0);
        nmi_in = 1'b0;
        cpu_mask = 1'b0;
        tick(3);
        per_en = 4'b0001;
        per_irq = 4'b0001;
        tick(1);
        chk("R4 peripheral presented", vec_out, 32);
        nmi_in = 1'b1;
        tick(4);
        chk("R9 held while nmi pends", vec_out, 32);
        ack = 1'b1;
        per_irq = '0;
        tick(1);
        ack = 1'b0;
        tick(1);
        chk("R4 nmi wins next", vec_out, 2);
        do_ack();
        nmi_in = 1'b0;
        per_en = '0;
        tick(3);
    endtask

    task automatic t_standby();
        standby = 1'b1;
        nmi_in = 1'b1;
        tick(6);
        chk("R11 nmi blocked in standby", irq_out, 0);
        standby = 1'b0;
        tick(4);
        chk("R11 edge not remembered", irq_out, 0);
        nmi_in = 1'b0;
        tick(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_enable_gate();
        t_prio_peripherals();
        t_mask_and_level();
        t_level_release();
        t_edge_pulse();
        t_edge_disabled_and_clear();
        t_nmi();
        t_standby();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule